// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the arithmetic and logic stage of a small integer datapath. Each cycle it takes an operation code, a destination operand and a source operand. It produces a 32-bit value and a write-enable that tells the surrounding register file whether to store that value. The value is computed combinationally.

Next to the data path it keeps a 4-bit status register holding zero, negative, carry and overflow. That register is loaded on the clock edge after a valid, known operation. Each operation has its own flag rule. Every update replaces all four bits, so no flag left over from an earlier operation survives.

Compare and bit-test only produce flags; they never raise the write-enable. The surrounding decode logic uses the flag register for conditional branches.

Top module: `flag_alu`

## Requirements
- R1: Add (op_sel 3'b000) gives result = dst_opnd + src_opnd modulo 2^32 with result_we high; carry is the unsigned carry-out of the sum.
- R2: Add sets overflow when both operands share bit 31 and the sum's bit 31 differs from it.
- R3: Subtract (op_sel 3'b001) gives result = dst_opnd - src_opnd with result_we high; carry is set when src_opnd > dst_opnd unsigned (a borrow); overflow is set when the operands' bit 31 differ and the difference's bit 31 differs from dst_opnd's bit 31.
- R4: Compare (op_sel 3'b010) sets flags exactly as subtract does on the same operands, but result_we stays low.
- R5: OR (op_sel 3'b011) and XOR (op_sel 3'b100) write the bitwise result with result_we high and clear carry and overflow.
- R6: Bit-test (op_sel 3'b101) sets zero and negative from dst_opnd AND src_opnd, clears carry and overflow, and keeps result_we low.
- R7: Zero is set exactly when the operation's 32-bit value is all zeros; negative equals bit 31 of that value.
- R8: flags is laid out {V,C,N,Z} from bit 3 down to bit 0. It changes only on the rising edge after a cycle with op_valid high and a known op_sel, and it holds when op_valid is low.
- R9: While rst_n is low, flags is 4'b0000.
- R10: op_sel 3'b110 and 3'b111 are unknown. With either code, result_we stays low and flags keeps its value even when op_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_sel | input | 3 | Operation code |
| dst_opnd | input | 32 | Destination operand (minuend, left side) |
| src_opnd | input | 32 | Source operand |
| result | output | 32 | Computed value, combinational |
| result_we | output | 1 | Result should be written back |
| flags | output | 4 | Status register {V,C,N,Z} |

## Verification
The assertions take for granted that op_valid, op_sel and both operands are settled before each rising edge. They also assume the operands stay stable for the whole cycle in which the strobe is high, because several checks relate flags to the previous cycle's result and operands. The bench changes every input only on the falling edge and leaves each operation on the inputs for a full cycle. It then drops the strobe, or issues the next operation, at the following falling edge. Unknown codes are driven with the strobe high on purpose, so that the hold property is exercised rather than skipped.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] dst_opnd,
  input  logic [W-1:0] src_opnd,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [3:0]   flags
);
  localparam int MSB = W - 1;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_CMP = 3'd2,
                         OP_OR  = 3'd3, OP_XOR = 3'd4, OP_BTST = 3'd5;

  logic [W:0]   sum_x, dif_x;
  logic [W-1:0] val;
  logic         c_nx, v_nx, known, wr;

  assign sum_x = {1'b0, dst_opnd} + {1'b0, src_opnd};
  assign dif_x = {1'b0, dst_opnd} - {1'b0, src_opnd};

  always_comb begin
    val   = '0;
    c_nx  = 1'b0;
    v_nx  = 1'b0;
    known = 1'b1;
    wr    = 1'b0;
    case (op_sel)
      OP_ADD: begin
        val  = sum_x[W-1:0];
        c_nx = sum_x[W];
        v_nx = (dst_opnd[MSB] == src_opnd[MSB]) && (sum_x[MSB] != dst_opnd[MSB]);
        wr   = 1'b1;
      end
      OP_SUB, OP_CMP: begin
        val  = dif_x[W-1:0];
        c_nx = dif_x[W];
        v_nx = (dst_opnd[MSB] != src_opnd[MSB]) && (dif_x[MSB] != dst_opnd[MSB]);
        wr   = (op_sel == OP_SUB);
      end
      OP_OR: begin
        val = dst_opnd | src_opnd;
        wr  = 1'b1;
      end
      OP_XOR: begin
        val = dst_opnd ^ src_opnd;
        wr  = 1'b1;
      end
      OP_BTST: val = dst_opnd & src_opnd;
      default: known = 1'b0;
    endcase
  end

  assign result    = val;
  assign result_we = op_valid & wr;

  always_ff @(posedge clk) begin
    if (!rst_n)
      flags <= 4'b0000;
    else if (op_valid && known)
      flags <= {v_nx, c_nx, val[MSB], (val == '0)};
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags));

  // R10
  bad_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel > OP_BTST) |=> $stable(flags));

  // R10
  bad_op_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OP_BTST) |-> !result_we);

  // R5
  logic_cv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == OP_OR || op_sel == OP_XOR || op_sel == OP_BTST))
      |=> flags[3:2] == 2'b00);

  // R7
  zn_from_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel <= OP_BTST)
      |=> (flags[0] == ($past(result) == '0)) && (flags[1] == $past(result[MSB])));

  // R1
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_ADD) |=> flags[2] == ($past(result) < $past(dst_opnd)));

  // R4
  cmp_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_CMP || op_sel == OP_BTST) |-> !result_we);
endmodule

// File: tb/test_flag_alu.sv
module test_flag_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [31:0] dst_opnd = '0;
  logic [31:0] src_opnd = '0;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  logic [3:0] mflags = 4'b0000;

  always #5 clk = ~clk;

  flag_alu #(.W(32)) i_flag_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .dst_opnd(dst_opnd), .src_opnd(src_opnd),
    .result(result), .result_we(result_we), .flags(flags));

  function automatic logic [31:0] ref_val(input logic [2:0] op, input logic [31:0] d, input logic [31:0] s);
    case (op)
      3'd0: return d + s;
      3'd1, 3'd2: return d - s;
      3'd3: return d | s;
      3'd4: return d ^ s;
      3'd5: return d & s;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic ref_we(input logic [2:0] op);
    return (op == 3'd0 || op == 3'd1 || op == 3'd3 || op == 3'd4);
  endfunction

  function automatic logic [3:0] ref_flags(input logic [2:0] op, input logic [31:0] d, input logic [31:0] s, input logic [3:0] old);
    logic [31:0] r;
    logic z, n, c, v;
    if (op > 3'd5) return old;
    r = ref_val(op, d, s);
    z = (r == 32'd0);
    n = r[31];
    c = 1'b0;
    v = 1'b0;
    if (op == 3'd0) begin
      c = (r < s) || (r < d);
      v = (d[31] == s[31]) && (r[31] != d[31]);
    end else if (op == 3'd1 || op == 3'd2) begin
      c = (s > d);
      v = (d[31] != s[31]) && (r[31] != d[31]);
    end
    return {v, c, n, z};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1/R2 add";
      3'd1: return "R3 sub";
      3'd2: return "R4 cmp";
      3'd3, 3'd4: return "R5 logic";
      3'd5: return "R6 btst";
      default: return "R10 unknown";
    endcase
  endfunction

  task automatic do_op(input logic [2:0] op, input logic [31:0] d, input logic [31:0] s);
    @(negedge clk);
    op_valid = 1'b1; op_sel = op; dst_opnd = d; src_opnd = s;
    #1;
    check({tag(op), " we"}, {31'd0, result_we}, {31'd0, ref_we(op)});
    if (op <= 3'd5) check({tag(op), " value R7"}, result, ref_val(op, d, s));
    mflags = ref_flags(op, d, s, mflags);
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    check({tag(op), " flags R8"}, {28'd0, flags}, {28'd0, mflags});
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] corner [4];
    void'($urandom(32'h1d2c3b4a));
    corner[0] = 32'h0000_0000; corner[1] = 32'h7FFF_FFFF;
    corner[2] = 32'h8000_0000; corner[3] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R9 reset flags", {28'd0, flags}, 32'd0);
    rst_n = 1'b1;
    // R2 directed overflow, R1 carry
    do_op(3'd0, 32'h7FFF_FFFF, 32'h0000_0001);
    do_op(3'd0, 32'hFFFF_FFFF, 32'h0000_0001);
    // R8 hold with strobe low
    @(negedge clk); #1;
    check("R8 idle hold", {28'd0, flags}, {28'd0, mflags});
    // R10 unknown ops with strobe high keep flags
    do_op(3'd6, 32'h1234_5678, 32'h1);
    do_op(3'd7, 32'h0, 32'h0);
    // R3 borrow and overflow, R4 cmp
    do_op(3'd1, 32'h8000_0000, 32'h0000_0001);
    do_op(3'd2, 32'h0000_0001, 32'h0000_0002);
    // R6 zero from AND
    do_op(3'd5, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    for (int op = 0; op < 6; op++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          do_op(op[2:0], corner[a], corner[b]);
    for (int k = 0; k < 400; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      do_op(op, $urandom, $urandom);
    end
    // R9 reset clears flags again
    do_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    check("R9 reset clears", {28'd0, flags}, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule